// File: doc/BRIEF.md
# Fast Eight-Point DCT Datapath

This block takes eight signed 8-bit samples in one clock cycle and computes a one-dimensional eight-point discrete cosine transform. It uses a factorised flow of six steps. Five of the steps are made only of additions, subtractions and pass-throughs. The fourth step applies integer constant multipliers scaled by 128. One product in that step is computed once and used by two lanes.

The block has one register stage per step, so a new set of samples can be accepted on every cycle. All eight results leave together from the final register bank, marked by a single valid strobe. Each result is 20 bits wide and carries full precision.

A per-sample round flag travels through the pipeline with its data. When the flag is set, each result is divided by 128 and rounded to the nearest integer, and the result then fits in 13 signed bits. A row/column engine for a 2-D transform would use this block as its one-dimensional kernel.

Top module: `dct8_fast`

## Requirements
- R1: Input lane m (m = 0..7) is the signed two's-complement byte at `x_i[8m+7:8m]`, sampled on a rising edge where `in_vld_i` is high.
- R2: Step one replaces lane m (m < 4) with x(m)+x(7-m) and lane m (m >= 4) with x(7-m)-x(m).
- R3: Step two (input s) produces: lane 0 = s0+s3, lane 1 = s1+s2, lane 2 = s1-s2, lane 3 = s0-s3, lane 4 = -(s4+s5), lane 5 = s5+s6, lane 6 = s6+s7, lane 7 = s7.
- R4: Step three (input d) produces: lane 0 = d0+d1, lane 1 = d0-d1, lane 2 = d2+d3, lane 4 = d4+d6. Lanes 3, 5, 6 and 7 are unchanged.
- R5: Step four (input e) forms t = 49·e4 once. It produces lane 2 = 90·e2, lane 4 = 69·e4+t, lane 5 = 90·e5 and lane 6 = 167·e6+t. Lanes 0, 1, 3 and 7 are unchanged.
- R6: Step five (input f) produces: lane 2 = f2+f3, lane 3 = f3-f2, lane 5 = f7+f5, lane 7 = f7-f5. Step six (input g) produces: y4 = g4+g7, y5 = g5+g6, y6 = g5-g6, y7 = g7+g4, and y0..y3 = g0..g3.
- R7: Result k is the 20-bit two's-complement value at `y_o[20k+19:20k]`. It is exact, with no wrap, for every possible input.
- R8: When `rnd_i` is high together with the samples, each result equals floor((v+64)/128), where v is the exact result. The rounded value is sign-extended to 20 bits and lies within -4096..4095.
- R9: `out_vld_o` is high in the sixth cycle after the cycle in which `in_vld_i` was high. It is high for one cycle per accepted sample set, and back-to-back sets are accepted every cycle.
- R10: All eight results update together, and only in a cycle where `out_vld_o` is high. Otherwise `y_o` keeps the last published set.
- R11: `rst` is synchronous and active high. It clears `out_vld_o`, every in-flight valid bit and `y_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Sample set on `x_i` is valid this cycle |
| rnd_i | input | 1 | Round the results of this sample set to integers |
| x_i | input | 64 | Eight signed 8-bit samples, lane m at bits 8m+7:8m |
| out_vld_o | output | 1 | A new result set is on `y_o` this cycle |
| y_o | output | 160 | Eight signed 20-bit results, lane k at bits 20k+19:20k |

## Verification
The assertions assume that `rst` is held high for at least one rising edge before operation starts. They also assume that `in_vld_i` and `rnd_i` are driven to known levels on every edge after that. The 13-bit bound on rounded results depends on the inputs being genuine signed bytes, so that intermediate magnitudes stay far below the 20-bit range. The stimulus changes inputs only on falling clock edges and keeps `in_vld_i` low during reset. It draws random bytes and random valid gaps from a fixed seed, and adds directed full-scale, alternating-sign and impulse patterns with rounding both on and off.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  localparam int LANES  = 8;
  localparam int IN_W   = 8;
  localparam int ACC_W  = 20;
  localparam int FRAC   = 7;
  localparam int RND_W  = 13;
  localparam int STAGES = 6;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [LANES-1:0][ACC_W-1:0] vec_t;

  // constant multipliers scaled by 2**FRAC
  localparam acc_t K_A1 = acc_t'(90);
  localparam acc_t K_A2 = acc_t'(69);
  localparam acc_t K_A3 = acc_t'(90);
  localparam acc_t K_A4 = acc_t'(167);
  localparam acc_t K_A5 = acc_t'(49);

  localparam acc_t RND_MAX = acc_t'(2**(RND_W-1) - 1);
  localparam acc_t RND_MIN = acc_t'(-(2**(RND_W-1)));
  localparam acc_t HALF    = acc_t'(2**(FRAC-1));

  function automatic acc_t lane(input vec_t v, input int i);
    return acc_t'(v[i]);
  endfunction

  // step 1: mirrored sum/difference
  function automatic vec_t bfly1(input vec_t s);
    vec_t r;
    for (int m = 0; m < LANES/2; m++) begin
      r[m]         = lane(s, m) + lane(s, LANES-1-m);
      r[LANES-1-m] = lane(s, m) - lane(s, LANES-1-m);
    end
    return r;
  endfunction

  // step 2: even half folded again, odd half paired
  function automatic vec_t bfly2(input vec_t s);
    vec_t r;
    r[0] = lane(s, 0) + lane(s, 3);
    r[1] = lane(s, 1) + lane(s, 2);
    r[2] = lane(s, 1) - lane(s, 2);
    r[3] = lane(s, 0) - lane(s, 3);
    r[4] = -lane(s, 4) - lane(s, 5);
    r[5] = lane(s, 5) + lane(s, 6);
    r[6] = lane(s, 6) + lane(s, 7);
    r[7] = lane(s, 7);
    return r;
  endfunction

  // step 3
  function automatic vec_t bfly3(input vec_t d);
    vec_t r;
    r    = d;
    r[0] = lane(d, 0) + lane(d, 1);
    r[1] = lane(d, 0) - lane(d, 1);
    r[2] = lane(d, 2) + lane(d, 3);
    r[4] = lane(d, 4) + lane(d, 6);
    return r;
  endfunction

  // step 4: scaled constant products, one shared term
  function automatic vec_t scale4(input vec_t e);
    vec_t r;
    acc_t shared;
    shared = lane(e, 4) * K_A5;
    r    = e;
    r[2] = lane(e, 2) * K_A1;
    r[4] = lane(e, 4) * K_A2 + shared;
    r[5] = lane(e, 5) * K_A3;
    r[6] = lane(e, 6) * K_A4 + shared;
    return r;
  endfunction

  // step 5
  function automatic vec_t bfly5(input vec_t f);
    vec_t r;
    r    = f;
    r[2] = lane(f, 2) + lane(f, 3);
    r[3] = lane(f, 3) - lane(f, 2);
    r[5] = lane(f, 7) + lane(f, 5);
    r[7] = lane(f, 7) - lane(f, 5);
    return r;
  endfunction

  // step 6
  function automatic vec_t bfly6(input vec_t g);
    vec_t r;
    r    = g;
    r[4] = lane(g, 4) + lane(g, 7);
    r[5] = lane(g, 5) + lane(g, 6);
    r[6] = lane(g, 5) - lane(g, 6);
    r[7] = lane(g, 7) + lane(g, 4);
    return r;
  endfunction

  // round half up after removing the 2**FRAC scale
  function automatic acc_t rnd_half(input acc_t v);
    acc_t t;
    t = v + HALF;
    return t >>> FRAC;
  endfunction

  function automatic vec_t round_all(input vec_t v);
    vec_t r;
    for (int k = 0; k < LANES; k++) r[k] = rnd_half(lane(v, k));
    return r;
  endfunction

endpackage

// File: rtl/dct8_widen.sv
module dct8_widen
  import dct8_pkg::*;
(
  input  logic [LANES*IN_W-1:0] x,
  output vec_t                  v
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign v[g] = ACC_W'($signed(x[g*IN_W +: IN_W]));
    end
  endgenerate

endmodule

// File: rtl/dct8_step.sv
module dct8_step
  import dct8_pkg::*;
#(
  parameter int STEP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic in_rnd,
  input  vec_t in_data,
  output logic out_vld,
  output logic out_rnd,
  output vec_t out_data
);

  vec_t nxt;

  generate
    case (STEP)
      1: begin : g_s1
        always_comb nxt = bfly1(in_data);
      end
      2: begin : g_s2
        always_comb nxt = bfly2(in_data);
      end
      3: begin : g_s3
        always_comb nxt = bfly3(in_data);
      end
      4: begin : g_s4
        always_comb nxt = scale4(in_data);
      end
      5: begin : g_s5
        always_comb nxt = bfly5(in_data);
      end
      6: begin : g_s6
        vec_t full;
        always_comb begin
          full = bfly6(in_data);
          nxt  = in_rnd ? round_all(full) : full;
        end
      end
      default: begin : g_pass
        always_comb nxt = in_data;
      end
    endcase
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_rnd  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_data <= nxt;
        out_rnd  <= in_rnd;
      end
    end
  end

  // armed: previous edge was outside reset
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r9_lat_step: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_vld == $past(in_vld)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(in_vld)) |-> $stable(out_data));

endmodule

// File: rtl/dct8_fast.sv
module dct8_fast
  import dct8_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld_i,
  input  logic         rnd_i,
  input  logic [63:0]  x_i,
  output logic         out_vld_o,
  output logic [159:0] y_o
);

  vec_t st_data [0:STAGES];
  logic st_vld  [0:STAGES];
  logic st_rnd  [0:STAGES];

  dct8_widen u_widen (
    .x (x_i),
    .v (st_data[0])
  );

  assign st_vld[0] = in_vld_i;
  assign st_rnd[0] = rnd_i;

  generate
    for (genvar k = 1; k <= STAGES; k++) begin : g_step
      dct8_step #(.STEP(k)) u_step (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (st_vld[k-1]),
        .in_rnd   (st_rnd[k-1]),
        .in_data  (st_data[k-1]),
        .out_vld  (st_vld[k]),
        .out_rnd  (st_rnd[k]),
        .out_data (st_data[k])
      );
    end
  endgenerate

  assign out_vld_o = st_vld[STAGES];
  assign y_o       = st_data[STAGES];

  // event wire: every published lane lies in the rounded range
  logic rnd_fits;
  always_comb begin
    rnd_fits = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (lane(st_data[STAGES], k) > RND_MAX || lane(st_data[STAGES], k) < RND_MIN)
        rnd_fits = 1'b0;
    end
  end

  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  a_r8_round_range: assert property (@(posedge clk) disable iff (rst)
    (out_vld_o && st_rnd[STAGES]) |-> rnd_fits);

  a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> (!out_vld_o && (y_o == '0)));

endmodule

// File: tb/sim_dct8_fast.sv
`timescale 1ns/1ps
module sim_dct8_fast;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_vld;
  logic         rnd;
  logic [63:0]  x;
  logic         out_vld;
  logic [159:0] y;

  always #4 clk = ~clk;   // 125 MHz

  dct8_fast u0 (
    .clk(clk), .rst(rst), .in_vld_i(in_vld), .rnd_i(rnd),
    .x_i(x), .out_vld_o(out_vld), .y_o(y)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [159:0] qy[$];
  int           qd[$];
  string        qt[$];
  logic [159:0] held = '0;

  task automatic chk(input bit ok, input string tag,
                     input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int fdiv128(input int v);
    int q;
    q = v / 128;
    if (v < 0 && (v % 128) != 0) q = q - 1;
    return q;
  endfunction

  // reference from the requirement equations, lane by lane
  function automatic logic [159:0] model(input logic [63:0] xin, input bit r);
    int xs[8];
    int a[8];
    int b[8];
    int c[8];
    int p[8];
    int q[8];
    int o[8];
    int sh;
    logic [159:0] res;
    for (int i = 0; i < 8; i++) xs[i] = int'($signed(xin[8*i +: 8]));
    a[0] = xs[0] + xs[7]; a[1] = xs[1] + xs[6]; a[2] = xs[2] + xs[5]; a[3] = xs[3] + xs[4];
    a[4] = xs[3] - xs[4]; a[5] = xs[2] - xs[5]; a[6] = xs[1] - xs[6]; a[7] = xs[0] - xs[7];
    b[0] = a[0] + a[3]; b[1] = a[1] + a[2]; b[2] = a[1] - a[2]; b[3] = a[0] - a[3];
    b[4] = -(a[4] + a[5]); b[5] = a[5] + a[6]; b[6] = a[6] + a[7]; b[7] = a[7];
    c = b;
    c[0] = b[0] + b[1]; c[1] = b[0] - b[1]; c[2] = b[2] + b[3]; c[4] = b[4] + b[6];
    sh = c[4] * 49;
    p = c;
    p[2] = c[2] * 90; p[4] = c[4] * 69 + sh; p[5] = c[5] * 90; p[6] = c[6] * 167 + sh;
    q = p;
    q[2] = p[2] + p[3]; q[3] = p[3] - p[2]; q[5] = p[7] + p[5]; q[7] = p[7] - p[5];
    o = q;
    o[4] = q[4] + q[7]; o[5] = q[5] + q[6]; o[6] = q[5] - q[6]; o[7] = q[7] + q[4];
    for (int i = 0; i < 8; i++) begin
      int v;
      v = r ? fdiv128(o[i] + 64) : o[i];
      res[20*i +: 20] = v[19:0];
    end
    return res;
  endfunction

  task automatic push(input bit v, input logic [63:0] xin, input bit r, input string tag);
    bit exp_v;
    @(negedge clk);
    in_vld = v; x = xin; rnd = r;
    @(posedge clk);
    cyc++;
    if (v) begin
      qy.push_back(model(xin, r));
      qd.push_back(cyc + 5);
      qt.push_back(tag);
    end
    #2;
    exp_v = (qd.size() > 0) && (qd[0] == cyc);
    chk(out_vld == exp_v, "R9", {159'd0, out_vld}, {159'd0, exp_v});
    if (exp_v) begin
      string t;
      held = qy.pop_front();
      void'(qd.pop_front());
      t = qt.pop_front();
      chk(y == held, t, y, held);
    end else begin
      chk(y == held, "R10", y, held);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk(out_vld == 1'b0 && y == '0, "R11", y, '0);
    @(negedge clk);
    rst = 1'b0;
    qy.delete(); qd.delete(); qt.delete();
    held = '0;
  endtask

  function automatic logic [63:0] fill(input logic [7:0] b);
    return {8{b}};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9: watchdog expired, actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    rst = 1'b1; in_vld = 1'b0; rnd = 1'b0; x = '0;
    do_reset();

    // R1: sign of each lane, lone negative byte in every lane position
    for (int i = 0; i < 8; i++) push(1, 64'h80 << (8*i), 0, "R1");
    push(1, 64'd0, 0, "R1");
    // R7: full-scale and alternating patterns, exact
    push(1, fill(8'h7F), 0, "R7");
    push(1, fill(8'h80), 0, "R7");
    push(1, 64'h807F807F807F807F, 0, "R7");
    push(1, 64'h7F807F807F807F80, 0, "R7");
    push(1, 64'h808080807F7F7F7F, 0, "R7");
    push(1, 64'h7F7F7F7F80808080, 0, "R7");
    push(1, 64'h7F80807F807F7F80, 0, "R7");
    // R2..R6: impulses expose each butterfly path
    for (int i = 0; i < 8; i++) push(1, 64'h7F << (8*i), 0, "R2");
    for (int i = 0; i < 8; i++) push(1, 64'h01 << (8*i), 0, "R3");
    // R8: rounding, including negative and half cases
    push(1, fill(8'h7F), 1, "R8");
    push(1, fill(8'h80), 1, "R8");
    push(1, 64'h807F807F807F807F, 1, "R8");
    for (int i = 0; i < 8; i++) push(1, 64'hFF << (8*i), 1, "R8");
    // R10: idle cycles hold the last set
    for (int i = 0; i < 10; i++) push(0, fill(8'h55), 1, "R10");

    // random, mixed valid gaps and round flag
    for (int i = 0; i < 600; i++) begin
      string tg;
      bit v;
      bit r;
      case (i % 5)
        0: tg = "R2";
        1: tg = "R3";
        2: tg = "R4";
        3: tg = "R5";
        default: tg = "R6";
      endcase
      v = ($urandom % 4) != 0;
      r = ($urandom % 3) == 0;
      if (r) tg = "R8";
      push(v, {$urandom, $urandom}, r, tg);
    end
    for (int i = 0; i < 8; i++) push(0, '0, 0, "R10");

    // R11: reset while sets are in flight
    for (int i = 0; i < 3; i++) push(1, {$urandom, $urandom}, 0, "R4");
    do_reset();
    for (int i = 0; i < 8; i++) push(0, '0, 0, "R11");
    for (int i = 0; i < 20; i++) push(1, {$urandom, $urandom}, 0, "R5");
    for (int i = 0; i < 8; i++) push(0, '0, 0, "R6");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule